// File: doc/BRIEF.md
# Descriptor-Driven Transmit DMA Sequencer

This block is the control sequencer of a transmit DMA engine. Software programs the address of a descriptor ring and then sets a single request bit in a 32-bit control register. The sequencer fetches the descriptor at its current pointer and looks at the descriptor's active flag. If the flag is set, it passes the buffer address and the frame length to a transmit datapath with a one-cycle start pulse and waits for the done pulse. It then moves the pointer to the next descriptor and fetches again.

The walk ends only when a fetched descriptor is inactive. At that point the hardware clears the request bit and the sequencer returns to idle. The pointer stays on the inactive descriptor, so a later start resumes there. Software writes to the request bit cannot stop a run or restart one that is already going.

A descriptor that carries the last-in-ring mark sends the pointer back to the programmed ring base instead of one descriptor size forward.

Top module: `txdesc_seq`

## Requirements
- R1: After reset the control register reads 0, no descriptor request is raised and no frame start is issued.
- R2: In the control register (regSel = 0) only bit 0, the request bit, is writable. Bits 31..1 always read 0 and ignore written ones.
- R3: Writing 1 to bit 0 while idle starts a run. Exactly one descriptor request is raised at the current pointer, and it stays valid until it is accepted.
- R4: For an active descriptor, txStart is a single-cycle pulse in the second cycle after the descriptor response is accepted, with txBufAddr and txLen equal to that descriptor's fields. txStart is never issued at any other time.
- R5: After txDone, the next descriptor is fetched at the previous pointer plus DESC_BYTES (16 by default).
- R6: After txDone for a descriptor whose last flag is set, the next fetch goes to the ring base.
- R7: An inactive descriptor ends the run. No frame is started for it. In the decision cycle (the cycle after its response is accepted) the control register already reads 0, and no further fetch follows.
- R8: Writing 0 to the request bit during a run has no effect. The bit keeps reading 1 and the run continues.
- R9: Writing 1 during a run is ignored. The descriptor walk neither restarts nor resets its pointer.
- R10: After a halt the pointer remains on the inactive descriptor, and the next start fetches that same address.
- R11: A write to the ring-base register (regSel = 1) while idle sets both the base and the pointer. The base reads back through regSel = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 = control, 1 = ring base |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regSel (combinational) |
| descReqValid | output | 1 | Descriptor fetch request valid |
| descReqReady | input | 1 | Descriptor fetch request accepted |
| descReqAddr | output | ADDR_W | Address of the requested descriptor |
| descRspReady | output | 1 | Sequencer can accept the descriptor response |
| descRspValid | input | 1 | Descriptor response valid (single beat) |
| descRspActive | input | 1 | Response: descriptor active flag |
| descRspLast | input | 1 | Response: last descriptor in ring |
| descRspBufAddr | input | ADDR_W | Response: frame buffer address |
| descRspLen | input | LEN_W | Response: frame length |
| txStart | output | 1 | One-cycle frame start to the transmit datapath |
| txBufAddr | output | ADDR_W | Buffer address of the frame being started |
| txLen | output | LEN_W | Length of the frame being started |
| txDone | input | 1 | Frame completion pulse from the transmit datapath |

## Verification
The hardest situation to create from the ports is the halt decision cycle. It lasts exactly one cycle, so the request bit has to be sampled at 1 in the response cycle and at 0 in the very next cycle. The bench uses a responsive descriptor memory model that answers every accepted request with a table entry, and it samples the control register in both of those cycles whenever an inactive entry is returned. Ring wrap and pointer retention depend on state left over from earlier runs. The bench rewrites memory entries between runs, so a restart lands on a now-active last descriptor that wraps onto a now-inactive first one.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;

  typedef enum logic [2:0] {
    IDLE,
    FETCH_DESC,
    CHECK_ACTIVE,
    SEND_FRAME,
    WAIT_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrReq;
    logic latchDesc;
    logic advance;
  } ctrlStb_t;

  // status from datapath to control
  typedef struct packed {
    logic reqBit;
    logic descActive;
  } dpStat_t;

  localparam int REG_W = 32;

endpackage

// File: rtl/txdesc_ctrl.sv
module txdesc_ctrl
  import txdesc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dpStat_t  stat,
  input  logic     descReqReady,
  input  logic     descRspValid,
  input  logic     txDone,
  output ctrlStb_t stb,
  output logic     descReqValid,
  output logic     descRspReady,
  output logic     txStart
);

  seqState_e state, nextState;
  logic      reqIssued;

  always_comb begin
    nextState    = state;
    stb          = '0;
    descReqValid = 1'b0;
    descRspReady = 1'b0;
    txStart      = 1'b0;
    case (state)
      IDLE: begin
        if (stat.reqBit) nextState = FETCH_DESC;
      end
      FETCH_DESC: begin
        descReqValid = !reqIssued;
        descRspReady = reqIssued;
        if (reqIssued && descRspValid) begin
          stb.latchDesc = 1'b1;
          nextState     = CHECK_ACTIVE;
        end
      end
      CHECK_ACTIVE: begin
        if (stat.descActive) begin
          nextState = SEND_FRAME;
        end else begin
          stb.clrReq = 1'b1;
          nextState  = IDLE;
        end
      end
      SEND_FRAME: begin
        txStart   = 1'b1;
        nextState = WAIT_DONE;
      end
      WAIT_DONE: begin
        if (txDone) begin
          stb.advance = 1'b1;
          nextState   = FETCH_DESC;
        end
      end
      default: nextState = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= IDLE;
      reqIssued <= 1'b0;
    end else begin
      state <= nextState;
      if (state != FETCH_DESC || stb.latchDesc)
        reqIssued <= 1'b0;
      else if (descReqValid && descReqReady)
        reqIssued <= 1'b1;
    end
  end

endmodule

// File: rtl/txdesc_dpath.sv
module txdesc_dpath
  import txdesc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  ctrlStb_t          stb,
  output dpStat_t           stat,
  input  logic              descRspActive,
  input  logic              descRspLast,
  input  logic [ADDR_W-1:0] descRspBufAddr,
  input  logic [LEN_W-1:0]  descRspLen,
  output logic [ADDR_W-1:0] descReqAddr,
  output logic [ADDR_W-1:0] txBufAddr,
  output logic [LEN_W-1:0]  txLen
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  logic              reqQ, activeQ, lastQ;
  logic [ADDR_W-1:0] baseQ, ptrQ, bufQ;
  logic [LEN_W-1:0]  lenQ;
  logic              setReq, wrBase;

  assign setReq = regWrEn && !regSel && regWrData[0];
  assign wrBase = regWrEn && regSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ    <= 1'b0;
      baseQ   <= '0;
      ptrQ    <= '0;
      activeQ <= 1'b0;
      lastQ   <= 1'b0;
      bufQ    <= '0;
      lenQ    <= '0;
    end else begin
      // request bit: only hardware clears it; writes of 0 are dropped
      if (stb.clrReq)  reqQ <= setReq;
      else if (setReq) reqQ <= 1'b1;

      if (wrBase) baseQ <= regWrData[ADDR_W-1:0];

      if (stb.advance)
        ptrQ <= lastQ ? baseQ : ptrQ + STEP;
      else if (wrBase && !reqQ)
        ptrQ <= regWrData[ADDR_W-1:0];

      if (stb.latchDesc) begin
        activeQ <= descRspActive;
        lastQ   <= descRspLast;
        bufQ    <= descRspBufAddr;
        lenQ    <= descRspLen;
      end
    end
  end

  // a read in the halt-decision cycle already sees the cleared bit
  assign regRdData = regSel ? REG_W'(baseQ)
                            : {{(REG_W-1){1'b0}}, reqQ && !stb.clrReq};

  assign stat.reqBit     = reqQ;
  assign stat.descActive = activeQ;
  assign descReqAddr     = ptrQ;
  assign txBufAddr       = bufQ;
  assign txLen           = lenQ;

endmodule

// File: rtl/txdesc_seq.sv
module txdesc_seq
  import txdesc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              descReqValid,
  input  logic              descReqReady,
  output logic [ADDR_W-1:0] descReqAddr,
  output logic              descRspReady,
  input  logic              descRspValid,
  input  logic              descRspActive,
  input  logic              descRspLast,
  input  logic [ADDR_W-1:0] descRspBufAddr,
  input  logic [LEN_W-1:0]  descRspLen,
  output logic              txStart,
  output logic [ADDR_W-1:0] txBufAddr,
  output logic [LEN_W-1:0]  txLen,
  input  logic              txDone
);

  ctrlStb_t ctrlStb;
  dpStat_t  dpStat;

  txdesc_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .stat         (dpStat),
    .descReqReady (descReqReady),
    .descRspValid (descRspValid),
    .txDone       (txDone),
    .stb          (ctrlStb),
    .descReqValid (descReqValid),
    .descRspReady (descRspReady),
    .txStart      (txStart)
  );

  txdesc_dpath #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .DESC_BYTES (DESC_BYTES)
  ) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .regWrEn        (regWrEn),
    .regSel         (regSel),
    .regWrData      (regWrData),
    .regRdData      (regRdData),
    .stb            (ctrlStb),
    .stat           (dpStat),
    .descRspActive  (descRspActive),
    .descRspLast    (descRspLast),
    .descRspBufAddr (descRspBufAddr),
    .descRspLen     (descRspLen),
    .descReqAddr    (descReqAddr),
    .txBufAddr      (txBufAddr),
    .txLen          (txLen)
  );

endmodule

// File: rtl/txdesc_chk.sv
module txdesc_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regSel,
  input logic [31:0] regRdData,
  input logic        descReqValid,
  input logic        descReqReady,
  input logic        descRspValid,
  input logic        descRspReady,
  input logic        descRspActive,
  input logic        txStart,
  input logic        reqBit,
  input logic        clrReq
);

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> regRdData[31:1] == 31'b0);

  // R3
  one_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    descReqValid && descReqReady |=> !descReqValid);

  // R4
  start_after_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> $past(descRspValid && descRspReady && descRspActive, 2));

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  // R7
  halt_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    descRspValid && descRspReady && !descRspActive |=> (regSel || !regRdData[0]) && !txStart);

  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    descRspValid && descRspReady && !descRspActive |=> ##1 (!txStart && !descReqValid));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqBit && !clrReq |=> reqBit);

endmodule

bind txdesc_seq txdesc_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .regSel        (regSel),
  .regRdData     (regRdData),
  .descReqValid  (descReqValid),
  .descReqReady  (descReqReady),
  .descRspValid  (descRspValid),
  .descRspReady  (descRspReady),
  .descRspActive (descRspActive),
  .txStart       (txStart),
  .reqBit        (dpStat.reqBit),
  .clrReq        (ctrlStb.clrReq)
);

// File: tb/tb_txdesc_seq.sv
module tb_txdesc_seq;

  // descriptor entry: {active, last, buf[31:0], len[15:0]}
  localparam logic [49:0] INIT_TAB [4] = '{
    {1'b1, 1'b0, 32'h0000_A000, 16'd64},
    {1'b1, 1'b0, 32'h0000_B100, 16'd1500},
    {1'b1, 1'b0, 32'h0000_C080, 16'd60},
    {1'b0, 1'b0, 32'h0000_D000, 16'd200}
  };
  localparam logic [31:0] EXP_FETCH_A [4] = '{
    32'h1000, 32'h1010, 32'h1020, 32'h1030
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        descReqValid, descReqReady, descRspReady, descRspValid;
  logic [31:0] descReqAddr;
  logic        descRspActive, descRspLast;
  logic [31:0] descRspBufAddr;
  logic [15:0] descRspLen;
  logic        txStart;
  logic [31:0] txBufAddr;
  logic [15:0] txLen;
  logic        txDone = 1'b0;

  logic [49:0] mem [8];
  logic [31:0] lastAddr = '0;
  logic [31:0] curBase = '0;
  logic [31:0] fetchLog [16];
  logic [31:0] frameBuf [16];
  logic [15:0] frameLen [16];
  int nFetch = 0, nFrame = 0, haltCnt = 0, doneCnt = 0;
  int checks = 0, errors = 0;
  logic pendHalt = 1'b0;
  logic [1:0] startPipe = 2'b00;
  logic [2:0] memIdx;

  always #4 clk = ~clk;

  assign descReqReady = 1'b1;
  assign descRspValid = descRspReady;
  assign memIdx = 3'((lastAddr - curBase) >> 4);
  assign {descRspActive, descRspLast, descRspBufAddr, descRspLen} = mem[memIdx];

  txdesc_seq dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData),
    .descReqValid(descReqValid), .descReqReady(descReqReady),
    .descReqAddr(descReqAddr), .descRspReady(descRspReady),
    .descRspValid(descRspValid), .descRspActive(descRspActive),
    .descRspLast(descRspLast), .descRspBufAddr(descRspBufAddr),
    .descRspLen(descRspLen), .txStart(txStart), .txBufAddr(txBufAddr),
    .txLen(txLen), .txDone(txDone)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic regWrite(input logic sel, input logic [31:0] d);
    @(posedge clk); #2;
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(posedge clk); #2;
    regWrEn = 1'b0; regSel = 1'b0; regWrData = '0;
  endtask

  task automatic waitHalt(input int target);
    while (haltCnt < target) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // port monitor and transmit/memory model, all at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      logic expStart;
      if (pendHalt) begin
        // R7: decision cycle already reads 0
        chk("R7 request bit in decision cycle", {31'b0, regRdData[0]}, 32'd0);
        pendHalt = 1'b0;
        haltCnt++;
      end
      expStart  = startPipe[1];
      startPipe = {startPipe[0], descRspValid && descRspReady && descRspActive};
      if (txStart || expStart)
        chk("R4 start pulse timing", {31'b0, txStart}, {31'b0, expStart});
      txDone = 1'b0;
      if (doneCnt > 0) begin
        doneCnt--;
        if (doneCnt == 0) txDone = 1'b1;
      end
      if (txStart) begin
        frameBuf[nFrame] = txBufAddr;
        frameLen[nFrame] = txLen;
        nFrame++;
        doneCnt = 3;
      end
      if (descRspValid && descRspReady && !descRspActive) begin
        chk("R7 request bit before decision", {31'b0, regRdData[0]}, 32'd1);
        pendHalt = 1'b1;
      end
      if (descReqValid && descReqReady) begin
        lastAddr = descReqAddr;
        fetchLog[nFetch] = descReqAddr;
        nFetch++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = (i < 4) ? INIT_TAB[i] : '0;
    repeat (5) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    chk("R1 control after reset", regRdData, 32'd0);
    chk("R1 no request after reset", {31'b0, descReqValid}, 32'd0);
    chk("R1 no start after reset", {31'b0, txStart}, 32'd0);

    // R2: upper bits ignored, bit 0 clear does not start
    regWrite(1'b0, 32'hFFFF_FFFE);
    repeat (4) @(negedge clk);
    chk("R2 upper bits read zero", regRdData, 32'd0);
    chk("R2 no run from zero bit", nFetch, 32'd0);

    // R11: program base
    regWrite(1'b1, 32'h0000_1000);
    curBase = 32'h1000;
    #1 regSel = 1'b1;
    @(negedge clk);
    chk("R11 base readback", regRdData, 32'h1000);
    #1 regSel = 1'b0;

    // scenario A: three active, one inactive
    regWrite(1'b0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R3 R2 control reads 1 only", regRdData, 32'd1);
    while (nFrame < 1) @(negedge clk);
    regWrite(1'b0, 32'h0);
    @(negedge clk);
    chk("R8 write 0 ignored", regRdData, 32'd1);
    while (nFrame < 2) @(negedge clk);
    regWrite(1'b0, 32'h1);
    waitHalt(1);
    chk("R5 fetch count A", nFetch, 32'd4);
    for (int i = 0; i < 4; i++)
      chk("R5 R9 fetch address A", fetchLog[i], EXP_FETCH_A[i]);
    chk("R7 frame count A", nFrame, 32'd3);
    for (int i = 0; i < 3; i++) begin
      chk("R4 frame buffer A", frameBuf[i], INIT_TAB[i][47:16]);
      chk("R4 frame length A", {16'b0, frameLen[i]}, {16'b0, INIT_TAB[i][15:0]});
    end
    chk("R7 control after halt", regRdData, 32'd0);

    // scenario B: resume at inactive slot, which is now active and last
    nFetch = 0; nFrame = 0;
    mem[3] = {1'b1, 1'b1, 32'h0000_D000, 16'd200};
    mem[0][49] = 1'b0;
    regWrite(1'b0, 32'h1);
    waitHalt(2);
    chk("R10 fetch count B", nFetch, 32'd2);
    chk("R10 resume address", fetchLog[0], 32'h1030);
    chk("R6 wrap to base", fetchLog[1], 32'h1000);
    chk("R4 frame count B", nFrame, 32'd1);
    chk("R4 frame buffer B", frameBuf[0], 32'h0000_D000);
    chk("R4 frame length B", {16'b0, frameLen[0]}, 32'd200);

    // scenario C: new base moves the pointer
    nFetch = 0; nFrame = 0;
    regWrite(1'b1, 32'h0000_2000);
    curBase = 32'h2000;
    regWrite(1'b0, 32'h1);
    waitHalt(3);
    chk("R11 fetch count C", nFetch, 32'd1);
    chk("R11 pointer follows base", fetchLog[0], 32'h2000);
    chk("R7 no frame for inactive", nFrame, 32'd0);

    summary();
  end

endmodule